// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This block is purely combinational. It inspects a 32-bit single-precision value and sorts it into one of six operand classes. It also reports whether the value is a NaN and whether that NaN is signaling. A mode input picks which polarity of the top fraction bit marks a quiet NaN: the legacy convention or the 2008 convention.

When the input is a signaling NaN, the block returns the quiet NaN produced by the rule for the selected mode and raises an invalid-operation indication. Every other input passes to the result unchanged and raises no indication. Arithmetic, trap delivery and any sticky flag storage belong to the surrounding datapath.

Top module: `fp_nan_unit`

## Requirements
- R1: `op_class` encodes the operand class as zero=0, denormal=1, normal=2, infinity=3, quiet NaN=4, signaling NaN=5. Exponent (bits 30:23) zero with fraction (bits 22:0) zero is zero. Exponent zero with a nonzero fraction is denormal. Exponent all ones with a zero fraction is infinity. Any other exponent is normal. The sign (bit 31) never affects the class.
- R2: `is_nan` is 1 exactly when the exponent is all ones and the fraction is nonzero.
- R3: A NaN is signaling, with `is_snan`=1 and class 5, when `nan2008_mode` XOR fraction bit 22 is 1. With mode 1, bit 22 clear marks a signaling NaN. With mode 0, bit 22 set marks a signaling NaN. Any other NaN has class 4 and `is_snan`=0.
- R4: With `nan2008_mode`=1, a signaling NaN is quieted by setting fraction bit 22. All other fraction bits are kept.
- R5: With `nan2008_mode`=0, a signaling NaN is quieted by clearing fraction bit 22. If the fraction is then all zero, fraction bit 21 is set so that the result remains a NaN.
- R6: `invalid_flag` is 1 exactly when the input is a signaling NaN.
- R7: For an input that is not a signaling NaN, `result` equals `op_in`.
- R8: The sign and exponent bits of `result` always equal those of `op_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Single-precision operand |
| nan2008_mode | input | 1 | 1: 2008 NaN polarity; 0: legacy polarity |
| op_class | output | 3 | Operand class code (see R1) |
| is_nan | output | 1 | Operand is a NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| result | output | 32 | Quieted NaN, or operand unchanged |
| invalid_flag | output | 1 | Invalid-operation indication for a signaling NaN |

## Verification
The block holds no state, so any wrong internal decision shows at the ports in the same evaluation as the input that caused it. A flipped polarity decode shows as swapped class codes 4 and 5, together with a result that was altered or left untouched wrongly. A missing fix-up for an empty fraction in legacy mode returns infinity instead of a NaN. Such an error appears only for the single fraction pattern with nothing but bit 22 set, so that pattern is driven explicitly in both modes along with a pseudo-random sweep that is biased toward NaN exponents.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;

    localparam int unsigned SP_EXP_W  = 8;
    localparam int unsigned SP_FRAC_W = 23;
    localparam int unsigned CLASS_W   = 3;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } op_class_e;

    typedef struct packed {
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic quiet_bit;
    } field_flags_t;

    function automatic op_class_e pick_class(input field_flags_t f, input logic signaling);
        op_class_e c;
        if (f.exp_ones && !f.frac_zero)
            c = signaling ? CLS_SNAN : CLS_QNAN;
        else if (f.exp_ones)
            c = CLS_INF;
        else if (f.exp_zero)
            c = f.frac_zero ? CLS_ZERO : CLS_DENORM;
        else
            c = CLS_NORMAL;
        return c;
    endfunction

endpackage

// File: rtl/fpn_unpack.sv
module fpn_unpack
    import fp_nan_pkg::*;
#(
    parameter int unsigned EXP_W  = SP_EXP_W,
    parameter int unsigned FRAC_W = SP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_in,
    output field_flags_t      flags
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              unused_sign;

    assign unused_sign = word_in[WORD_W-1];
    assign exp_f  = word_in[FRAC_W +: EXP_W];
    assign frac_f = word_in[FRAC_W-1:0];

    always_comb begin
        flags.exp_ones  = &exp_f;
        flags.exp_zero  = ~|exp_f;
        flags.frac_zero = ~|frac_f;
        flags.quiet_bit = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fpn_classify.sv
module fpn_classify
    import fp_nan_pkg::*;
(
    input  field_flags_t flags,
    input  logic         mode_2008,
    output op_class_e    cls,
    output logic         nan_o,
    output logic         snan_o
);
    logic nan_w;
    logic sig_w;

    always_comb begin
        nan_w  = flags.exp_ones && !flags.frac_zero;
        sig_w  = nan_w && (mode_2008 ^ flags.quiet_bit);
        cls    = pick_class(flags, sig_w);
        nan_o  = nan_w;
        snan_o = sig_w;
    end
endmodule

// File: rtl/fpn_quieter.sv
module fpn_quieter
    import fp_nan_pkg::*;
#(
    parameter int unsigned EXP_W  = SP_EXP_W,
    parameter int unsigned FRAC_W = SP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              mode_2008,
    input  logic              do_quiet,
    output logic [WORD_W-1:0] word_out,
    output logic              quieted
);
    localparam int unsigned TOP = FRAC_W - 1;
    localparam int unsigned NXT = FRAC_W - 2;

    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W-1:0] frac_new;
    logic [FRAC_W-1:0] frac_leg;

    assign frac_in = word_in[FRAC_W-1:0];

    always_comb begin
        frac_leg      = frac_in;
        frac_leg[TOP] = 1'b0;
        if (frac_leg == '0)
            frac_leg[NXT] = 1'b1;
        if (mode_2008) begin
            frac_new      = frac_in;
            frac_new[TOP] = 1'b1;
        end else begin
            frac_new = frac_leg;
        end
        word_out = do_quiet ? {word_in[WORD_W-1:FRAC_W], frac_new} : word_in;
        quieted  = do_quiet && (frac_new != frac_in);
    end
endmodule

// File: rtl/fp_nan_unit.sv
module fp_nan_unit
    import fp_nan_pkg::*;
#(
    parameter int unsigned EXP_W  = SP_EXP_W,
    parameter int unsigned FRAC_W = SP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0]  op_in,
    input  logic               nan2008_mode,
    output logic [CLASS_W-1:0] op_class,
    output logic               is_nan,
    output logic               is_snan,
    output logic [WORD_W-1:0]  result,
    output logic               invalid_flag
);
    field_flags_t flags;
    op_class_e    cls;
    logic         snan_w;

    fpn_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .word_in (op_in),
        .flags   (flags)
    );

    fpn_classify u_classify (
        .flags     (flags),
        .mode_2008 (nan2008_mode),
        .cls       (cls),
        .nan_o     (is_nan),
        .snan_o    (snan_w)
    );

    fpn_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quieter (
        .word_in   (op_in),
        .mode_2008 (nan2008_mode),
        .do_quiet  (snan_w),
        .word_out  (result),
        .quieted   (invalid_flag)
    );

    assign op_class = cls;
    assign is_snan  = snan_w;
endmodule

// File: rtl/fp_nan_unit_chk.sv
module fp_nan_unit_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned FRAC_W = 23
) (
    input logic [WORD_W-1:0] op_in,
    input logic              nan2008_mode,
    input logic [2:0]        op_class,
    input logic              is_nan,
    input logic              is_snan,
    input logic [WORD_W-1:0] result,
    input logic              invalid_flag
);
    logic res_exp_ones;
    logic res_frac_nz;

    always_comb begin
        res_exp_ones = &result[WORD_W-2:FRAC_W];
        res_frac_nz  = |result[FRAC_W-1:0];
        p_sign_exp_kept_r8: assert (result[WORD_W-1:FRAC_W] == op_in[WORD_W-1:FRAC_W]);
        p_passthrough_r7: assert (is_snan || result == op_in);
        p_snan_is_nan_r3: assert (!is_snan || is_nan);
        p_flag_tracks_snan_r6: assert (invalid_flag == is_snan);
        p_quiet_stays_nan_r5: assert (!is_snan || (res_exp_ones && res_frac_nz
                                      && result[FRAC_W-1] == nan2008_mode));
        p_nan_class_r2: assert (is_nan == (op_class == 3'd4 || op_class == 3'd5));
        p_inf_class_r1: assert (op_class != 3'd3 || (res_exp_ones && !res_frac_nz));
    end
endmodule

bind fp_nan_unit fp_nan_unit_chk #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_chk (
    .op_in        (op_in),
    .nan2008_mode (nan2008_mode),
    .op_class     (op_class),
    .is_nan       (is_nan),
    .is_snan      (is_snan),
    .result       (result),
    .invalid_flag (invalid_flag)
);

// File: tb/fp_nan_unit_tb.sv
module fp_nan_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_in = '0;
    logic        nan2008_mode = 1'b0;
    logic [2:0]  op_class;
    logic        is_nan, is_snan, invalid_flag;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fp_nan_unit u_dut (
        .op_in(op_in), .nan2008_mode(nan2008_mode), .op_class(op_class),
        .is_nan(is_nan), .is_snan(is_snan), .result(result),
        .invalid_flag(invalid_flag)
    );

    // Behavioural reference built from the requirements
    int          e_cls;
    bit          e_nan, e_snan, e_inv;
    bit   [31:0] e_res;

    task automatic model(input bit [31:0] v, input bit m);
        int ex = (v >> 23) & 255;
        int fr = v & 32'h7FFFFF;
        int q  = (fr >> 22) & 1;
        e_nan  = (ex == 255) && (fr != 0);
        e_snan = e_nan && ((m ? 1 : 0) != q);
        if (e_nan) e_cls = e_snan ? 5 : 4;
        else if (ex == 255) e_cls = 3;
        else if (ex == 0) e_cls = (fr == 0) ? 0 : 1;
        else e_cls = 2;
        e_inv = e_snan;
        e_res = v;
        if (e_snan) begin
            if (m) fr = fr + 32'h400000;
            else begin
                fr = fr - 32'h400000;
                if (fr == 0) fr = 32'h200000;
            end
            e_res = (v & 32'hFF800000) | fr;
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input bit [31:0] v, input bit m);
        @(negedge clk);
        op_in = v;
        nan2008_mode = m;
        #2;
        model(v, m);
        chk("R1", "class", op_class, e_cls);
        chk("R2", "is_nan", is_nan, e_nan);
        chk("R3", "is_snan", is_snan, e_snan);
        chk("R6", "invalid_flag", invalid_flag, e_inv);
        if (e_snan) chk(m ? "R4" : "R5", "quieted result", result, e_res);
        else chk("R7", "passthrough", result, e_res);
        chk("R8", "sign/exponent", result[31:23], v[31:23]);
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        bit [31:0] lfsr = 32'hACE1_2357;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: zero input reads as class zero with no flag (R1)
        apply(32'h0000_0000, 1'b0);
        for (int m = 0; m < 2; m++) begin
            apply(32'h8000_0000, m[0]);            // R1 negative zero
            apply(32'h0000_0001, m[0]);            // R1 denormal
            apply(32'h807F_FFFF, m[0]);            // R1 negative denormal
            apply(32'h3F80_0000, m[0]);            // R1 normal
            apply(32'h7F7F_FFFF, m[0]);            // R1 largest normal
            apply(32'h7F80_0000, m[0]);            // R1 +infinity
            apply(32'hFF80_0000, m[0]);            // R1 -infinity
            apply(32'h7FC0_0000, m[0]);            // R3 bit22 only: R5 fix-up in legacy
            apply(32'hFFC0_0000, m[0]);            // R5 fix-up with sign set
            apply(32'h7F80_0001, m[0]);            // R4 quiet in 2008 mode
            apply(32'hFFBF_FFFF, m[0]);            // R4 all low bits set
            apply(32'h7FFF_FFFF, m[0]);            // R5 legacy clears bit22
            apply(32'h7FC0_0001, m[0]);            // R5 no fix-up needed
            apply(32'h7FA0_0000, m[0]);            // R3
        end
        for (int i = 0; i < 2000; i++) begin
            bit [31:0] v;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            v = lfsr;
            if (lfsr[3:2] != 2'b00) v[30:23] = 8'hFF;       // bias toward NaN/inf
            if (lfsr[7:4] == 4'h0) v[21:0] = '0;            // hit the fix-up pattern
            apply(v, lfsr[9]);
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule